// File: doc/BRIEF.md
# Flash Power-Mode and Reset Sequencer

This block is the control logic of a NOR-style flash device that decides when the data pins may drive and which power state the device is in. It watches the chip-select, output-enable and power-down/reset pins, plus a busy flag from the program/erase engine. From these it produces an output-driver enable, standby and deep power-down indications, an abort request to the engine, and separate read-ready and write-ready flags that hold off accesses until the wake-up delays have passed.

A reset pin held low long enough in normal operation puts the device into deep power-down. Shorter pulses are filtered out. If the pin falls while the engine is busy, a fixed-length abort window starts instead. When that window closes, the device either powers down, if the pin is still low, or starts its wake-up sequence at once. In both cases the wake-up delays are counted from the end of the window, not from the rising edge of the pin. Each time the device comes out of reset, it sends one strobe that returns the command interface to read-array mode and loads the status register with 0x80.

All timing values are parameters given in clock cycles: `T_PLPH` (reset qualify), `T_PLRH` (abort window), `T_PHQV` (read wake-up) and `T_PHWL` (write wake-up).

Top module: `flash_pwr_seq`

## Requirements
- R1: `out_drv_en` is high only when `chip_sel_n` is low, `out_en_n` is low and `rd_ready` is high. It is low in every cycle in which `out_en_n` is high.
- R2: While `chip_sel_n` is high, `out_drv_en` is low. `standby` is high unless the engine is busy or the device is powered down or aborting. When `chip_sel_n` falls with the device ready, `out_drv_en` rises in the same cycle, with no extra latency.
- R3: While `eng_busy` is high, `standby` stays low even with `chip_sel_n` high. `standby` rises in the same cycle that `eng_busy` falls.
- R4: In normal operation with the engine idle, if `pwr_rst_n` is sampled low on `T_PLPH` consecutive clock edges, `deep_pd` is high from the cycle after the last of those edges. A low pulse of fewer samples leaves every output as it would have been without the pulse.
- R5: While `deep_pd` is high, `out_drv_en`, `standby`, `rd_ready` and `wr_ready` are all low.
- R6: When the device leaves power-down (because `pwr_rst_n` is sampled high) or closes an abort window with `pwr_rst_n` high, it enters wake-up. Call the first wake-up cycle cycle 0. `rd_ready` is high from cycle `T_PHQV` and `wr_ready` is high from cycle `T_PHWL`. Both stay high until the next reset entry.
- R7: `cui_reset` and `sr_preset` are high together for exactly one cycle, wake-up cycle 0, on every entry into wake-up.
- R8: If `pwr_rst_n` is first sampled low while `eng_busy` is high, `eng_abort` is high for exactly `T_PLRH` cycles starting in the next cycle. During that window `out_drv_en`, `standby`, `rd_ready` and `wr_ready` are low.
- R9: `abort_done` is high for exactly one cycle, the last cycle of the abort window.
- R10: At the close of the abort window, `pwr_rst_n` is sampled. If it is low, `deep_pd` rises in the next cycle. If it is high, wake-up cycle 0 is the next cycle, however early `pwr_rst_n` rose.
- R11: If `pwr_rst_n` is sampled low during wake-up, the next cycle is power-down, with `deep_pd` high and both ready flags low.
- R12: While `rst_n` is low and after its release, the block is in power-down (`deep_pd` high, both ready flags low) until `pwr_rst_n` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| chip_sel_n | input | 1 | Active-low device select |
| out_en_n | input | 1 | Active-low output enable |
| pwr_rst_n | input | 1 | Active-low reset / deep power-down pin |
| eng_busy | input | 1 | Program/erase engine is running |
| out_drv_en | output | 1 | Data-pin driver enable (low means high impedance) |
| standby | output | 1 | Device is in low-power standby |
| deep_pd | output | 1 | Device is in deep power-down |
| eng_abort | output | 1 | Abort request to the program/erase engine |
| abort_done | output | 1 | Pulse: aborted location/block is now invalid |
| cui_reset | output | 1 | Pulse: return command interface to read-array |
| sr_preset | output | 1 | Pulse: load status register with 0x80 |
| rd_ready | output | 1 | Read wake-up delay has elapsed |
| wr_ready | output | 1 | Write wake-up delay has elapsed |

## Verification
The following hold on every cycle:
- power-down and abort keep the drivers, standby and both ready flags low;
- a busy engine always blocks standby;
- the abort window never runs past `T_PLRH` cycles and opens only from a busy reset fall;
- the interface-reset strobe is one cycle long;
- a window always closes into power-down or wake-up cycle 0.

Some behaviour can be shown only by the bench scenarios, which compare each output every cycle against a reference model:
- the exact cycle at which each ready flag rises;
- that the wake-up count starts at the end of the abort window rather than at the pin's rising edge;
- that reset pulses shorter than the qualify time have no effect;
- that an early or a late release picks the correct exit from the abort window.

// File: rtl/fps_pkg.sv
package fps_pkg;

  // Sequencer states
  typedef enum logic [2:0] {
    FS_PDN   = 3'd0,   // deep power-down / held in reset
    FS_WAKE  = 3'd1,   // counting wake-up delays
    FS_RUN   = 3'd2,   // normal operation
    FS_QUAL  = 3'd3,   // reset low, not yet qualified
    FS_ABORT = 3'd4    // aborting a program/erase
  } fps_state_e;

  // Shared cycle counter operations
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_CLR  = 2'd1,
    CNT_ONE  = 2'd2,
    CNT_INC  = 2'd3
  } cnt_op_e;

  function automatic int fps_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fps_counter.sv
module fps_counter
  import fps_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cnt_op_e       op,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_nxt;
  logic          cnt_en;

  always_comb begin
    cnt_en  = (op != CNT_HOLD);
    cnt_nxt = cnt;
    unique case (op)
      CNT_CLR:  cnt_nxt = '0;
      CNT_ONE:  cnt_nxt = CW'(1);
      CNT_INC:  cnt_nxt = cnt + CW'(1);
      default:  cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/fps_fsm.sv
module fps_fsm
  import fps_pkg::*;
#(
  parameter int T_PLPH = 8,
  parameter int T_PLRH = 12,
  parameter int T_PHQV = 5,
  parameter int T_PHWL = 10,
  parameter int CW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_rst_n,
  input  logic          eng_busy,
  input  logic [CW-1:0] cnt,
  output fps_state_e    state,
  output cnt_op_e       cnt_op
);

  localparam int            WAKE_SPAN  = fps_max(T_PHQV, T_PHWL);
  localparam logic [CW-1:0] QUAL_LAST  = CW'(T_PLPH - 1);
  localparam logic [CW-1:0] ABORT_LAST = CW'(T_PLRH - 1);
  localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_SPAN - 1);
  localparam bit            QUAL_SKIP  = (T_PLPH <= 1);

  fps_state_e state_nxt;
  logic       state_en;

  always_comb begin
    state_nxt = state;
    cnt_op    = CNT_HOLD;
    unique case (state)
      FS_PDN: begin
        if (pwr_rst_n) begin
          state_nxt = FS_WAKE;
          cnt_op    = CNT_CLR;
        end
      end
      FS_WAKE: begin
        if (!pwr_rst_n) begin
          state_nxt = FS_PDN;
        end else if (cnt == WAKE_LAST) begin
          state_nxt = FS_RUN;
          cnt_op    = CNT_CLR;
        end else begin
          cnt_op    = CNT_INC;
        end
      end
      FS_RUN: begin
        if (!pwr_rst_n) begin
          if (eng_busy) begin
            state_nxt = FS_ABORT;
            cnt_op    = CNT_CLR;
          end else if (QUAL_SKIP) begin
            state_nxt = FS_PDN;
          end else begin
            state_nxt = FS_QUAL;
            cnt_op    = CNT_ONE;
          end
        end
      end
      FS_QUAL: begin
        if (pwr_rst_n) begin
          state_nxt = FS_RUN;
        end else if (cnt == QUAL_LAST) begin
          state_nxt = FS_PDN;
        end else begin
          cnt_op    = CNT_INC;
        end
      end
      FS_ABORT: begin
        if (cnt == ABORT_LAST) begin
          if (pwr_rst_n) begin
            state_nxt = FS_WAKE;
            cnt_op    = CNT_CLR;
          end else begin
            state_nxt = FS_PDN;
          end
        end else begin
          cnt_op = CNT_INC;
        end
      end
      default: begin
        state_nxt = FS_PDN;
      end
    endcase
  end

  assign state_en = (state_nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FS_PDN;
    end else if (state_en) begin
      state <= state_nxt;
    end
  end

endmodule

// File: rtl/fps_out.sv
module fps_out
  import fps_pkg::*;
#(
  parameter int T_PLRH = 12,
  parameter int T_PHQV = 5,
  parameter int T_PHWL = 10,
  parameter int CW     = 5
) (
  input  fps_state_e    state,
  input  logic [CW-1:0] cnt,
  input  logic          chip_sel_n,
  input  logic          out_en_n,
  input  logic          eng_busy,
  output logic          out_drv_en,
  output logic          standby,
  output logic          deep_pd,
  output logic          eng_abort,
  output logic          abort_done,
  output logic          cui_reset,
  output logic          sr_preset,
  output logic          rd_ready,
  output logic          wr_ready
);

  localparam logic [CW-1:0] RD_AT      = CW'(T_PHQV);
  localparam logic [CW-1:0] WR_AT      = CW'(T_PHWL);
  localparam logic [CW-1:0] ABORT_LAST = CW'(T_PLRH - 1);

  logic awake;      // device powered, neither aborting nor down
  logic wake_first;

  always_comb begin
    rd_ready = 1'b0;
    wr_ready = 1'b0;
    unique case (state)
      FS_RUN, FS_QUAL: begin
        rd_ready = 1'b1;
        wr_ready = 1'b1;
      end
      FS_WAKE: begin
        rd_ready = (cnt >= RD_AT);
        wr_ready = (cnt >= WR_AT);
      end
      default: begin
        rd_ready = 1'b0;
        wr_ready = 1'b0;
      end
    endcase
  end

  always_comb begin
    awake      = (state == FS_RUN) || (state == FS_QUAL) || (state == FS_WAKE);
    wake_first = (state == FS_WAKE) && (cnt == '0);
    out_drv_en = !chip_sel_n && !out_en_n && rd_ready;
    standby    = chip_sel_n && !eng_busy && awake;
    deep_pd    = (state == FS_PDN);
    eng_abort  = (state == FS_ABORT);
    abort_done = eng_abort && (cnt == ABORT_LAST);
    cui_reset  = wake_first;
    sr_preset  = wake_first;
  end

endmodule

// File: rtl/flash_pwr_seq.sv
module flash_pwr_seq
  import fps_pkg::*;
#(
  parameter int T_PLPH = 8,
  parameter int T_PLRH = 12,
  parameter int T_PHQV = 5,
  parameter int T_PHWL = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel_n,
  input  logic out_en_n,
  input  logic pwr_rst_n,
  input  logic eng_busy,
  output logic out_drv_en,
  output logic standby,
  output logic deep_pd,
  output logic eng_abort,
  output logic abort_done,
  output logic cui_reset,
  output logic sr_preset,
  output logic rd_ready,
  output logic wr_ready
);

  localparam int T_MAX = fps_max(fps_max(T_PLPH, T_PLRH), fps_max(T_PHQV, T_PHWL));
  localparam int CW    = $clog2(T_MAX + 1) + 1;

  fps_state_e    state;
  cnt_op_e       cnt_op;
  logic [CW-1:0] cnt;

  fps_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (cnt_op),
    .cnt   (cnt)
  );

  fps_fsm #(
    .T_PLPH (T_PLPH),
    .T_PLRH (T_PLRH),
    .T_PHQV (T_PHQV),
    .T_PHWL (T_PHWL),
    .CW     (CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_rst_n (pwr_rst_n),
    .eng_busy  (eng_busy),
    .cnt       (cnt),
    .state     (state),
    .cnt_op    (cnt_op)
  );

  fps_out #(
    .T_PLRH (T_PLRH),
    .T_PHQV (T_PHQV),
    .T_PHWL (T_PHWL),
    .CW     (CW)
  ) u_out (
    .state      (state),
    .cnt        (cnt),
    .chip_sel_n (chip_sel_n),
    .out_en_n   (out_en_n),
    .eng_busy   (eng_busy),
    .out_drv_en (out_drv_en),
    .standby    (standby),
    .deep_pd    (deep_pd),
    .eng_abort  (eng_abort),
    .abort_done (abort_done),
    .cui_reset  (cui_reset),
    .sr_preset  (sr_preset),
    .rd_ready   (rd_ready),
    .wr_ready   (wr_ready)
  );

endmodule

// File: rtl/fps_chk.sv
module fps_chk #(
  parameter int T_PLRH = 12
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_rst_n,
  input logic eng_busy,
  input logic out_drv_en,
  input logic standby,
  input logic deep_pd,
  input logic eng_abort,
  input logic abort_done,
  input logic cui_reset,
  input logic sr_preset,
  input logic rd_ready,
  input logic wr_ready
);

  int abort_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_run <= 0;
    end else if (eng_abort) begin
      abort_run <= abort_run + 1;
    end else begin
      abort_run <= 0;
    end
  end

  a_r1_drv_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    out_drv_en |-> (!deep_pd && !eng_abort));

  a_r3_busy_blocks_standby: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !standby);

  a_r4_pdn_needs_low_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deep_pd) |-> $past(!pwr_rst_n));

  a_r5_pdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    deep_pd |-> (!out_drv_en && !standby && !rd_ready && !wr_ready));

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cui_reset |=> !cui_reset);

  a_r7_strobes_paired: assert property (@(posedge clk) disable iff (!rst_n)
    cui_reset |-> sr_preset);

  a_r8_abort_from_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_abort) |-> $past(!pwr_rst_n && eng_busy));

  a_r8_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> (abort_run < T_PLRH));

  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> (!standby && !rd_ready && !wr_ready));

  a_r9_done_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |-> eng_abort);

  a_r9_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |=> !eng_abort);

  a_r10_close_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_abort) |-> (deep_pd || cui_reset));

  a_r11_wake_interrupt: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ready && !deep_pd && !eng_abort && !pwr_rst_n) |=> deep_pd);

endmodule

bind flash_pwr_seq fps_chk #(.T_PLRH(T_PLRH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_rst_n  (pwr_rst_n),
  .eng_busy   (eng_busy),
  .out_drv_en (out_drv_en),
  .standby    (standby),
  .deep_pd    (deep_pd),
  .eng_abort  (eng_abort),
  .abort_done (abort_done),
  .cui_reset  (cui_reset),
  .sr_preset  (sr_preset),
  .rd_ready   (rd_ready),
  .wr_ready   (wr_ready)
);

// File: tb/sim_flash_pwr_seq.sv
`timescale 1ns/1ps
module sim_flash_pwr_seq;

  localparam int P_PLPH = 4;
  localparam int P_PLRH = 6;
  localparam int P_PHQV = 3;
  localparam int P_PHWL = 5;
  localparam int SPAN   = (P_PHQV > P_PHWL) ? P_PHQV : P_PHWL;

  localparam int M_PDN = 0, M_WAKE = 1, M_NORM = 2, M_ABORT = 3;

  logic clk, rst_n, chip_sel_n, out_en_n, pwr_rst_n, eng_busy;
  logic out_drv_en, standby, deep_pd, eng_abort, abort_done;
  logic cui_reset, sr_preset, rd_ready, wr_ready;

  int checks, failures;
  bit done;

  flash_pwr_seq #(
    .T_PLPH(P_PLPH), .T_PLRH(P_PLRH), .T_PHQV(P_PHQV), .T_PHWL(P_PHWL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .pwr_rst_n(pwr_rst_n), .eng_busy(eng_busy), .out_drv_en(out_drv_en),
    .standby(standby), .deep_pd(deep_pd), .eng_abort(eng_abort),
    .abort_done(abort_done), .cui_reset(cui_reset), .sr_preset(sr_preset),
    .rd_ready(rd_ready), .wr_ready(wr_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference model
  int mode, low_run, abort_age, wake_age;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = M_PDN; low_run = 0; abort_age = 0; wake_age = 0;
    end else begin
      case (mode)
        M_PDN: if (pwr_rst_n) begin mode = M_WAKE; wake_age = 0; end
        M_WAKE: begin
          if (!pwr_rst_n) mode = M_PDN;
          else if (wake_age + 1 >= SPAN) begin mode = M_NORM; low_run = 0; end
          else wake_age = wake_age + 1;
        end
        M_NORM: begin
          if (!pwr_rst_n) begin
            if (low_run == 0 && eng_busy) begin mode = M_ABORT; abort_age = 0; end
            else begin
              low_run = low_run + 1;
              if (low_run >= P_PLPH) mode = M_PDN;
            end
          end else low_run = 0;
        end
        default: begin
          abort_age = abort_age + 1;
          if (abort_age == P_PLRH) begin
            mode = pwr_rst_n ? M_WAKE : M_PDN;
            wake_age = 0;
          end
        end
      endcase
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_rd, e_wr, e_up;
      e_rd = (mode == M_NORM) || (mode == M_WAKE && wake_age >= P_PHQV);
      e_wr = (mode == M_NORM) || (mode == M_WAKE && wake_age >= P_PHWL);
      e_up = (mode == M_NORM) || (mode == M_WAKE);
      chk("R1 out_drv_en", out_drv_en, !chip_sel_n && !out_en_n && e_rd);
      chk("R3 standby", standby, chip_sel_n && !eng_busy && e_up);
      chk("R4 deep_pd", deep_pd, mode == M_PDN);
      chk("R6 rd_ready", rd_ready, e_rd);
      chk("R6 wr_ready", wr_ready, e_wr);
      chk("R7 cui_reset", cui_reset, mode == M_WAKE && wake_age == 0);
      chk("R7 sr_preset", sr_preset, mode == M_WAKE && wake_age == 0);
      chk("R8 eng_abort", eng_abort, mode == M_ABORT);
      chk("R9 abort_done", abort_done, mode == M_ABORT && abort_age == P_PLRH - 1);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic obs();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; chip_sel_n = 1'b1; out_en_n = 1'b1; pwr_rst_n = 1'b0; eng_busy = 1'b0;
    tick(3);
    obs();
    chk("R12 deep_pd in reset", deep_pd, 1'b1);
    chk("R12 rd_ready in reset", rd_ready, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    tick(2); obs();
    chk("R12 deep_pd after release", deep_pd, 1'b1);

    // Wake-up timing
    pwr_rst_n = 1'b1;
    tick(1); obs();
    chk("R7 cui_reset at wake 0", cui_reset, 1'b1);
    tick(P_PHQV - 1); obs();
    chk("R6 rd not yet", rd_ready, 1'b0);
    tick(1); obs();
    chk("R6 rd ready", rd_ready, 1'b1);
    tick(P_PHWL - P_PHQV - 1); obs();
    chk("R6 wr not yet", wr_ready, 1'b0);
    tick(1); obs();
    chk("R6 wr ready", wr_ready, 1'b1);
    tick(2);

    // Output enable and standby
    chip_sel_n = 1'b0; out_en_n = 1'b0; obs();
    chk("R1 drive on", out_drv_en, 1'b1);
    tick(1); out_en_n = 1'b1; obs();
    chk("R1 oe high tristates", out_drv_en, 1'b0);
    tick(1); chip_sel_n = 1'b1; out_en_n = 1'b0; obs();
    chk("R2 deselect tristates", out_drv_en, 1'b0);
    chk("R2 deselect standby", standby, 1'b1);
    tick(2); chip_sel_n = 1'b0; obs();
    chk("R2 no latency after standby", out_drv_en, 1'b1);

    // Busy holds active power
    tick(1); chip_sel_n = 1'b1; eng_busy = 1'b1; obs();
    chk("R3 busy not standby", standby, 1'b0);
    tick(3); eng_busy = 1'b0; obs();
    chk("R3 standby after busy", standby, 1'b1);

    // Short reset pulse ignored, then qualified power-down
    tick(1); pwr_rst_n = 1'b0;
    tick(P_PLPH - 1); pwr_rst_n = 1'b1; obs();
    chk("R4 short pulse no pdn", deep_pd, 1'b0);
    chk("R4 short pulse rd kept", rd_ready, 1'b1);
    tick(2); pwr_rst_n = 1'b0; chip_sel_n = 1'b0; out_en_n = 1'b0;
    tick(P_PLPH - 1); obs();
    chk("R4 not yet pdn", deep_pd, 1'b0);
    tick(1); obs();
    chk("R4 pdn entered", deep_pd, 1'b1);
    chk("R5 pdn drivers off", out_drv_en, 1'b0);
    chk("R5 pdn wr off", wr_ready, 1'b0);
    tick(3);

    // Reset during wake-up
    pwr_rst_n = 1'b1; tick(2); pwr_rst_n = 1'b0; tick(1); obs();
    chk("R11 back to pdn", deep_pd, 1'b1);
    chk("R11 rd cleared", rd_ready, 1'b0);
    pwr_rst_n = 1'b1; tick(SPAN + 3);

    // Abort with early release: wake counted from window end
    chip_sel_n = 1'b1; eng_busy = 1'b1; pwr_rst_n = 1'b0;
    tick(1); obs();
    chk("R8 abort raised", eng_abort, 1'b1);
    pwr_rst_n = 1'b1; eng_busy = 1'b0;
    tick(P_PLRH - 1); obs();
    chk("R9 done at last cycle", abort_done, 1'b1);
    tick(1); obs();
    chk("R10 wake 0 after window", cui_reset, 1'b1);
    tick(P_PHQV - 1); obs();
    chk("R10 rd not early", rd_ready, 1'b0);
    tick(1); obs();
    chk("R10 rd from window end", rd_ready, 1'b1);
    tick(SPAN + 2);

    // Abort with pin held low: power-down
    eng_busy = 1'b1; pwr_rst_n = 1'b0;
    tick(P_PLRH); obs();
    chk("R10 still aborting", eng_abort, 1'b1);
    chk("R10 not pdn yet", deep_pd, 1'b0);
    tick(1); obs();
    chk("R10 held low pdn", deep_pd, 1'b1);
    eng_busy = 1'b0; pwr_rst_n = 1'b1; tick(SPAN + 2);

    // Mixed patterns, model compared every cycle
    for (int i = 0; i < 800; i++) begin
      chip_sel_n = (((i >> 2) ^ (i >> 5)) & 1) != 0;
      out_en_n   = ((i >> 3) & 1) != 0;
      eng_busy   = (i % 23) < 9;
      pwr_rst_n  = !((i % 41) >= 30 && (i % 41) < 30 + ((i / 41) % 9));
      tick(1);
    end
    pwr_rst_n = 1'b1; tick(SPAN + 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule